// File: doc/BRIEF.md
# Sampling Phase Centering Controller

This controller picks the sampling phase at which an ADC should digitize a time-multiplexed analog stream. Once the first multiplexer slot has been located, a training pattern holds one slot at a distinct level and the rest at another. The contrast between them, measured downstream, stays high while samples land on settled levels and drops when they land on switching transients. The controller steps an external PLL's dynamic phase shift one increment at a time and reads back a contrast value after every step.

It takes a reference contrast at the starting phase. It then walks the phase upward until the contrast is at or below half of that reference, which gives the upper edge. Next it walks downward from there until the contrast, having first recovered above the threshold, again falls to it, which gives the lower edge. It then steps upward to the midpoint of the two edges and reports completion. If either walk uses up its step allowance without finding an edge, it stops and raises an error flag. The phase position it reports is a signed count of net steps since the search began.

Top module: `phase_center_search`

## Requirements
- R1: After reset, step_o, done_o and err_o are 0 and pos_o is 0.
- R2: start_i is accepted only while lock_i is 1 and no search is running. A start with lock_i at 0 issues no step and leaves done_o, err_o and pos_o unchanged.
- R3: An accepted start clears pos_o to 0, clears done_o and err_o, and captures the first metric_i that arrives with metric_valid_i as the reference. The threshold is the reference shifted right by one (floor of half). A sample is "low" when metric_i is less than or equal to the threshold.
- R4: Each phase step is a single-cycle step_o pulse, with step_up_o = 1 meaning increase and 0 meaning decrease. No further step is issued until step_done_i has been seen. During both searches the controller then also waits for one metric_valid_i sample after that acknowledge and evaluates it. Samples that arrive before the acknowledge are ignored.
- R5: The upward search increases the phase by one per step. The upper edge is pos_o at the first evaluated sample that is low.
- R6: The downward search starts at the upper edge and decreases the phase by one per step. A low sample counts as the lower edge only after at least one sample in this search was above the threshold.
- R7: The centre is upper − floor((upper − lower)/2), rounded toward the upper edge. The controller steps upward, waiting for step_done_i after each step, until pos_o equals the centre. It then raises done_o and holds it until the next accepted start.
- R8: If either search has issued MAX_STEPS steps without finding its edge, err_o rises and no more steps are issued. err_o is held until the next accepted start. done_o and err_o are never 1 together.
- R9: An accepted start while done_o or err_o is held clears both flags and begins a new search from position 0.
- R10: pos_o is a two's-complement POS_W-bit count. It changes by exactly ±1 on the clock edge that ends each step_o cycle and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_i | input | 1 | First multiplexer slot has been identified |
| start_i | input | 1 | Begin a search (single-cycle pulse) |
| metric_i | input | METRIC_W | Training contrast value |
| metric_valid_i | input | 1 | metric_i carries a fresh sample |
| step_o | output | 1 | One-cycle request for one PLL phase increment |
| step_up_o | output | 1 | Direction of step_o: 1 increase, 0 decrease |
| step_done_i | input | 1 | PLL reports that the requested step is complete |
| done_o | output | 1 | Search finished at the centre phase |
| err_o | output | 1 | An edge was not found within MAX_STEPS |
| pos_o | output | POS_W | Signed net phase position since start |

## Verification
On every cycle, the embedded assertions check the following: step_o is a single-cycle pulse; the position moves only on a step and is otherwise held; the step budget never runs past its limit; the reference is held between captures; the two completion flags are never both high; completion arrives only on an acknowledge; and an idle or finished controller stays quiet when a start arrives without lock. Only the bench's scenarios can show that the edges and the centre land at the right phases. These scenarios cover a symmetric contrast peak, an asymmetric peak with an odd edge span, a zero reference that needs the recovery rule, exhaustion in each direction, junk samples before acknowledges, and restarts from both end states.

// File: rtl/pcs_pkg.sv
// Package pcs_pkg: shared state and direction types for the phase centering
// controller. Assumes nothing beyond being compiled before its users.
package pcs_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_REF,
        S_ISSUE,
        S_ACK,
        S_MEAS,
        S_C_ISSUE,
        S_C_ACK,
        S_DONE,
        S_ERR
    } pcs_state_e;

    typedef enum logic {
        LEG_UP,
        LEG_DOWN
    } pcs_leg_e;

endpackage

// File: rtl/pcs_phase_acc.sv
// pcs_phase_acc: signed net phase position. It clears on request and moves by
// one per step in the requested direction.
// Assumes clr_i and step_i are never requested in the same cycle by the owner.
module pcs_phase_acc #(
    parameter int POS_W = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clr_i,
    input  logic                    step_i,
    input  logic                    up_i,
    output logic signed [POS_W-1:0] pos_o
);

    logic signed [POS_W-1:0] pos_q;

    // Track the net number of increments minus decrements.
    always_ff @(posedge clk) begin
        if (!rst_n)      pos_q <= '0;
        else if (clr_i)  pos_q <= '0;
        else if (step_i) pos_q <= up_i ? pos_q + POS_W'(1) : pos_q - POS_W'(1);
    end

    assign pos_o = pos_q;

    // R10
    pos_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !step_i) |=> $stable(pos_q));

    // R10
    pos_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !clr_i) |=> !$stable(pos_q));

endmodule

// File: rtl/pcs_contrast_judge.sv
// pcs_contrast_judge: holds the reference contrast and flags samples at or
// below half of it. Assumes load_i is pulsed once per search, with a valid sample.
module pcs_contrast_judge #(
    parameter int METRIC_W = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [METRIC_W-1:0] metric_i,
    output logic                low_o
);

    logic [METRIC_W-1:0] ref_q;
    logic [METRIC_W-1:0] thresh;

    // Capture the reference contrast at the starting phase.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_q <= '0;
        else if (load_i) ref_q <= metric_i;
    end

    // Half of the reference, rounded down, and the comparison against it.
    always_comb begin
        thresh = ref_q >> 1;
        low_o  = (metric_i <= thresh);
    end

    // R3
    ref_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(ref_q));

endmodule

// File: rtl/pcs_step_budget.sv
// pcs_step_budget: counts the steps taken in the current search and reports
// when MAX_STEPS have been used. Assumes the owner stops incrementing once spent.
module pcs_step_budget #(
    parameter int MAX_STEPS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic inc_i,
    output logic spent_o
);

    localparam int CNT_W = $clog2(MAX_STEPS + 1);

    logic [CNT_W-1:0] cnt_q;

    // Count steps issued since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cnt_q + CNT_W'(1);
    end

    assign spent_o = (cnt_q == CNT_W'(MAX_STEPS));

    // R8
    budget_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(MAX_STEPS));

    // R8
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (spent_o && !clr_i) |-> !inc_i);

endmodule

// File: rtl/phase_center_search.sv
// phase_center_search: steps a PLL phase shift to find the two half-contrast
// edges of the training pattern, then settles at their midpoint.
// Assumes one step_done_i per step_o, and that metric_i reflects the current
// phase for every metric_valid_i that follows the acknowledge.
module phase_center_search
    import pcs_pkg::*;
#(
    parameter int METRIC_W  = 12,
    parameter int POS_W     = 8,
    parameter int MAX_STEPS = 64
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    lock_i,
    input  logic                    start_i,
    input  logic [METRIC_W-1:0]     metric_i,
    input  logic                    metric_valid_i,
    output logic                    step_o,
    output logic                    step_up_o,
    input  logic                    step_done_i,
    output logic                    done_o,
    output logic                    err_o,
    output logic signed [POS_W-1:0] pos_o
);

    pcs_state_e              state_q, state_d;
    pcs_leg_e                leg_q, leg_d;
    logic                    armed_q, armed_d;
    logic signed [POS_W-1:0] upper_q, upper_d;
    logic signed [POS_W-1:0] mid_q, mid_d;
    logic signed [POS_W-1:0] pos;
    logic signed [POS_W-1:0] span;
    logic                    idle_like, go, ref_load, eval, low, spent;
    logic                    budget_clr, center_step;

    // Decode the handshake-level strobes from the current state.
    always_comb begin
        idle_like   = (state_q == S_IDLE) || (state_q == S_DONE) || (state_q == S_ERR);
        go          = idle_like && start_i && lock_i;
        ref_load    = (state_q == S_REF) && metric_valid_i;
        eval        = (state_q == S_MEAS) && metric_valid_i;
        center_step = (state_q == S_C_ISSUE);
        step_o      = (state_q == S_ISSUE) || center_step;
        step_up_o   = center_step || (leg_q == LEG_UP);
        done_o      = (state_q == S_DONE);
        err_o       = (state_q == S_ERR);
        budget_clr  = ref_load || (eval && low && (leg_q == LEG_UP));
        span        = upper_q - pos;
    end

    pcs_phase_acc #(.POS_W(POS_W)) i_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (go),
        .step_i (step_o),
        .up_i   (step_up_o),
        .pos_o  (pos)
    );

    pcs_contrast_judge #(.METRIC_W(METRIC_W)) i_judge (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (ref_load),
        .metric_i (metric_i),
        .low_o    (low)
    );

    pcs_step_budget #(.MAX_STEPS(MAX_STEPS)) i_budget (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (budget_clr),
        .inc_i   (state_q == S_ISSUE),
        .spent_o (spent)
    );

    assign pos_o = pos;

    // Next-state logic for the search, edge recording and centring.
    always_comb begin
        state_d = state_q;
        leg_d   = leg_q;
        armed_d = armed_q;
        upper_d = upper_q;
        mid_d   = mid_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_ERR: begin
                if (go) begin
                    state_d = S_REF;
                    leg_d   = LEG_UP;
                    armed_d = 1'b0;
                end
            end
            S_REF:     if (metric_valid_i) state_d = S_ISSUE;
            S_ISSUE:   state_d = S_ACK;
            S_ACK:     if (step_done_i) state_d = S_MEAS;
            S_MEAS: begin
                if (eval) begin
                    if (leg_q == LEG_UP) begin
                        if (low) begin
                            upper_d = pos;
                            leg_d   = LEG_DOWN;
                            armed_d = 1'b0;
                            state_d = S_ISSUE;
                        end else begin
                            state_d = spent ? S_ERR : S_ISSUE;
                        end
                    end else begin
                        if (low && armed_q) begin
                            mid_d   = upper_q - (span >>> 1);
                            state_d = S_C_ISSUE;
                        end else begin
                            if (!low) armed_d = 1'b1;
                            state_d = spent ? S_ERR : S_ISSUE;
                        end
                    end
                end
            end
            S_C_ISSUE: state_d = S_C_ACK;
            S_C_ACK: begin
                if (step_done_i) state_d = (pos == mid_q) ? S_DONE : S_C_ISSUE;
            end
            default:   state_d = S_IDLE;
        endcase
    end

    // Register the controller state and the recorded edge and centre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            leg_q   <= LEG_UP;
            armed_q <= 1'b0;
            upper_q <= '0;
            mid_q   <= '0;
        end else begin
            state_q <= state_d;
            leg_q   <= leg_d;
            armed_q <= armed_d;
            upper_q <= upper_d;
            mid_q   <= mid_d;
        end
    end

    // R4
    step_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_o |=> !step_o);

    // R8
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && err_o));

    // R7
    done_on_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(step_done_i));

    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_like && !lock_i) |=> (!step_o && $stable(pos_o) && $stable(done_o) && $stable(err_o)));

endmodule

// File: tb/test_phase_center_search.sv
`timescale 1ns/1ps
// Bench: a PLL and contrast-source model driven behaviourally, with the
// expected step sequence planned in a queue and compared on every clock.
module test_phase_center_search;

    localparam int MW  = 12;
    localparam int PW  = 8;
    localparam int MAX = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lock_i = 1'b0;
    logic start_i = 1'b0;
    logic [MW-1:0] metric_i = '0;
    logic metric_valid_i = 1'b0;
    logic step_done_i = 1'b0;
    logic step_o, step_up_o, done_o, err_o;
    logic signed [PW-1:0] pos_o;

    int n_checks = 0;
    int n_fail = 0;

    // curve and PLL model state
    int cc = 0, cpk = 0, csu = 0, csd = 0;
    int ph = 0;
    bit pending = 0;
    bit pdir = 0;
    int ack_cnt = 0;
    int tick = 0;

    // expectation state
    bit exp_q[$];
    int mpos = 0;
    bit chk_en = 0;
    bit exp_done, exp_err;
    int exp_pos;

    always #2.5 clk = ~clk;

    phase_center_search #(.METRIC_W(MW), .POS_W(PW), .MAX_STEPS(MAX)) i_phase_center_search (
        .clk(clk), .rst_n(rst_n), .lock_i(lock_i), .start_i(start_i),
        .metric_i(metric_i), .metric_valid_i(metric_valid_i),
        .step_o(step_o), .step_up_o(step_up_o), .step_done_i(step_done_i),
        .done_o(done_o), .err_o(err_o), .pos_o(pos_o)
    );

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    function automatic int curve(input int p);
        int v;
        if (p >= cc) v = cpk - csu * (p - cc);
        else         v = cpk - csd * (cc - p);
        if (v < 0) v = 0;
        if (v > 4095) v = 4095;
        return v;
    endfunction

    // Plan the expected step directions and the outcome from the requirements.
    task automatic plan_run();
        int p, thr, upper, lower, mid;
        bit found, armed;
        p = 0;
        thr = curve(0) / 2;
        exp_q.delete();
        found = 0;
        upper = 0;
        lower = 0;
        for (int k = 0; k < MAX; k++) begin
            p++;
            exp_q.push_back(1'b1);
            if (curve(p) <= thr) begin upper = p; found = 1; break; end
        end
        if (!found) begin exp_err = 1; exp_done = 0; exp_pos = p; return; end
        armed = 0;
        found = 0;
        for (int j = 0; j < MAX; j++) begin
            p--;
            exp_q.push_back(1'b0);
            if (curve(p) > thr) armed = 1;
            else if (armed) begin lower = p; found = 1; break; end
        end
        if (!found) begin exp_err = 1; exp_done = 0; exp_pos = p; return; end
        mid = upper - (upper - lower) / 2;
        while (p < mid) begin p++; exp_q.push_back(1'b1); end
        exp_done = 1;
        exp_err = 0;
        exp_pos = mid;
    endtask

    // PLL acknowledge and contrast source model.
    initial begin
        forever begin
            @(negedge clk);
            step_done_i = 1'b0;
            metric_valid_i = 1'b0;
            if (ack_cnt > 0) begin
                ack_cnt--;
                if (ack_cnt == 0) begin
                    step_done_i = 1'b1;
                    ph = pdir ? ph + 1 : ph - 1;
                    pending = 0;
                end
            end
            if (step_o) begin
                pending = 1;
                pdir = step_up_o;
                ack_cnt = 4;
            end
            tick++;
            if (tick % 3 == 0) begin
                metric_valid_i = 1'b1;
                metric_i = pending ? '0 : MW'(curve(ph));
            end
        end
    end

    // Per-clock comparison against the planned sequence.
    initial begin
        forever begin
            @(negedge clk);
            if (chk_en) begin
                check(pos_o == mpos, "R10 position", int'(pos_o), mpos);
                if (exp_q.size() != 0)
                    check(!done_o && !err_o, "R7 flags low while searching", int'({done_o, err_o}), 0);
                if (step_o) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R4 unexpected step", 1, 0);
                    end else begin
                        check(step_up_o == exp_q[0], "R5 R6 step direction", int'(step_up_o), int'(exp_q[0]));
                        mpos = exp_q[0] ? mpos + 1 : mpos - 1;
                        void'(exp_q.pop_front());
                    end
                end
            end
        end
    end

    task automatic run_case(input int c, input int pk, input int su, input int sd, input string tag);
        bit fin;
        @(negedge clk); #1;
        chk_en = 0;
        cc = c; cpk = pk; csu = su; csd = sd;
        ph = 0;
        plan_run();
        @(negedge clk);
        lock_i = 1'b1;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        #1;
        check(!done_o && !err_o, "R9 flags cleared by start", int'({done_o, err_o}), 0);
        mpos = 0;
        chk_en = 1;
        fin = 0;
        for (int t = 0; t < 4000; t++) begin
            @(negedge clk); #1;
            if (done_o || err_o) begin fin = 1; break; end
        end
        check(fin, {tag, " watchdog"}, int'(fin), 1);
        check(done_o == exp_done, {tag, " done"}, int'(done_o), int'(exp_done));
        check(err_o == exp_err, {tag, " err"}, int'(err_o), int'(exp_err));
        check(pos_o == exp_pos, {tag, " final pos"}, int'(pos_o), exp_pos);
        check(exp_q.size() == 0, "R4 all steps issued", exp_q.size(), 0);
        repeat (6) @(negedge clk);
        #1;
        check(done_o == exp_done && err_o == exp_err, "R7 R8 flags held", int'({done_o, err_o}), int'({exp_done, exp_err}));
        chk_en = 0;
    endtask

    // Global watchdog.
    initial begin
        #900000;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        int hold_pos;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        // R1
        check(!step_o && !done_o && !err_o, "R1 reset outputs", int'({step_o, done_o, err_o}), 0);
        check(pos_o == 0, "R1 reset pos", int'(pos_o), 0);

        // R2: start without lock at idle
        lock_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        #1;
        check(!step_o && !done_o && !err_o && pos_o == 0, "R2 start ignored when unlocked", int'(pos_o), 0);

        // symmetric peak: edges 13 and -3, centre 5 (R3 R5 R6 R7)
        run_case(5, 400, 40, 40, "R7 symmetric");

        // R2: start without lock after completion keeps state
        hold_pos = int'(pos_o);
        @(negedge clk);
        lock_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (30) @(negedge clk);
        #1;
        check(done_o && !err_o && pos_o == hold_pos, "R2 unlocked start after done", int'(pos_o), hold_pos);

        // asymmetric peak: edges 2 and -5, odd span, centre -1 (R7 rounding)
        run_case(0, 400, 100, 40, "R7 odd span");

        // zero reference: recovery rule needed, edges 1 and -12, centre -5 (R6)
        run_case(-6, 300, 50, 50, "R6 arming");

        // flat contrast: upward search exhausts (R8)
        run_case(0, 300, 0, 0, "R8 upward exhaust");

        // restart after error, downward search exhausts (R8 R9)
        run_case(0, 400, 100, 0, "R8 downward exhaust");

        // restart after error into a normal search (R9)
        run_case(3, 500, 60, 60, "R9 restart");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule